// File: doc/BRIEF.md
# Converter Output Test Pattern Selector

This block sits between a data converter's sample path and its serial output formatter. On each sample strobe it passes one word downstream. That word is either the converter sample or a known digital pattern, so the receiver at the far end of the link can confirm that its capture and timing are right. A 4-bit mode input picks the source. The sources are live data, three fixed words, two words that alternate on successive samples, two pseudorandom streams fed in from a separate generator, and a user pattern of four words built from eight byte registers.

The active word length can be set from 8 to 14 bits. The output word is right-justified, and every pattern is rebuilt for the chosen length. When the format select is set, an offset-binary to two's-complement conversion flips the top active bit. Each mode decides for itself whether this conversion applies. An internal phase counter sets which word of an alternating or cycling pattern is sent. The counter restarts whenever the selected mode differs from the mode of the previous sample.

Top module: `test_pattern_sel`

## Requirements
- R1: While rst_n is low, and after its release until the first strobe, word_o is 0 and valid_o is 0.
- R2: A sample taken while smp_en_i is high appears on word_o one clock later, with valid_o high for that single cycle. With no strobe, valid_o is low and word_o holds its last value.
- R3: Mode 0000, and every unused code from 1001 to 1111, passes adc_data_i through, limited to the active length.
- R4: Mode 0001 gives only the top active bit set (midscale). Mode 0010 gives all active bits set. Mode 0011 gives zero. Each of these repeats on every sample.
- R5: Mode 0100 alternates two words. Word 1 has a one in the top active bit and in every second bit below it (0xAAA at 12 bits). Word 2 is its complement within the active length (0x555 at 12 bits). Mode 0111 alternates all active bits set (word 1) and zero (word 2).
- R6: With fmt_twos_i = 1, the top active bit of the word is inverted in every mode except 0100, 0111 and 1000, which ignore fmt_twos_i.
- R7: Mode 0101 passes pn_long_i and mode 0110 passes pn_short_i, each limited to the active length.
- R8: Mode 1000 cycles through four words. Word k is {byte 2k+1, byte 2k}, where byte n is user_bytes_i[8n+7:8n]. Each word is truncated to its low active-length bits.
- R9: The first sample whose mode differs from the previous sample's mode (the mode after reset counts as 0000) sends word 1 of the pattern. Each further sample in the same mode advances by one word, modulo 2 for modes 0100 and 0111 and modulo 4 for mode 1000.
- R10: The active length L is wlen_i, limited to the range 8 to 14: smaller values give 8 and larger values give 14. Bits of word_o at position L and above are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en_i | input | 1 | Sample strobe, one output word per high cycle |
| mode_i | input | 4 | Pattern mode code |
| fmt_twos_i | input | 1 | Two's-complement format select |
| wlen_i | input | 4 | Requested word length |
| adc_data_i | input | 14 | Converter sample, offset binary, right-justified |
| pn_long_i | input | 14 | Word from the long pseudorandom generator |
| pn_short_i | input | 14 | Word from the short pseudorandom generator |
| user_bytes_i | input | 64 | Eight user pattern bytes, byte n at bits 8n+7:8n |
| word_o | output | 14 | Output sample word, right-justified |
| valid_o | output | 1 | High for one cycle when word_o carries a new sample |

## Verification
Every result of this block is due exactly one clock after the strobe edge that captured its inputs. This covers the pattern word, the format flip, the length masking and the valid pulse. The bench drives inputs on the falling edge, lets one rising edge register them, and compares word_o and valid_o on the next falling edge. Its own phase counter tracks the mode of the previous sample, so the word expected from an alternating or cycling pattern is known for every sample, including the first sample after a mode change. Idle cycles are checked on the falling edge that follows a rising edge with no strobe, to confirm that the word held and the valid pulse stayed low.

// File: rtl/tp_pkg.sv
package tp_pkg;

  localparam logic [3:0] MODE_OFF = 4'b0000;
  localparam logic [3:0] MODE_MID = 4'b0001;
  localparam logic [3:0] MODE_POS = 4'b0010;
  localparam logic [3:0] MODE_NEG = 4'b0011;
  localparam logic [3:0] MODE_CHK = 4'b0100;
  localparam logic [3:0] MODE_PNL = 4'b0101;
  localparam logic [3:0] MODE_PNS = 4'b0110;
  localparam logic [3:0] MODE_TGL = 4'b0111;
  localparam logic [3:0] MODE_USR = 4'b1000;

  // Modes whose output takes part in the two's-complement flip.
  function automatic logic fmt_applies(input logic [3:0] m);
    return !(m == MODE_CHK || m == MODE_TGL || m == MODE_USR);
  endfunction

endpackage

// File: rtl/tp_len_dec.sv
module tp_len_dec #(
  parameter int MIN_W = 8,
  parameter int MAX_W = 14,
  localparam int LW = $clog2(MAX_W + 1)
) (
  input  logic [LW-1:0]    wlen_i,
  output logic [MAX_W-1:0] mask_o,
  output logic [MAX_W-1:0] msb_o,
  output logic [MAX_W-1:0] alt_o
);

  int len;

  always_comb begin
    len = int'(wlen_i);
    if (len < MIN_W) len = MIN_W;
    if (len > MAX_W) len = MAX_W;
  end

  // Per-bit decode of active mask, top bit and alternating word.
  for (genvar i = 0; i < MAX_W; i++) begin : g_bit
    assign mask_o[i] = (i < len);
    assign msb_o[i]  = (i == len - 1);
    assign alt_o[i]  = (i < len) && (((len - 1 - i) % 2) == 0);
  end

endmodule

// File: rtl/tp_phase.sv
module tp_phase #(
  parameter int NW = 4,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en_i,
  input  logic [3:0]    mode_i,
  output logic [IW-1:0] idx_o
);

  logic [3:0]    last_q, last_d;
  logic [IW-1:0] ph_q, ph_d;
  logic          changed;

  assign changed = (mode_i != last_q);
  assign idx_o   = changed ? '0 : ph_q;

  always_comb begin
    last_d = last_q;
    ph_d   = ph_q;
    if (smp_en_i) begin
      last_d = mode_i;
      if (idx_o == IW'(NW - 1)) ph_d = '0;
      else                      ph_d = idx_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 4'b0000;
      ph_q   <= '0;
    end else if (smp_en_i) begin
      last_q <= last_d;
      ph_q   <= ph_d;
    end
  end

  // R9
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && changed) |=> (ph_q == IW'(1 % NW)));

  // R9
  hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en_i |=> ($stable(ph_q) && $stable(last_q)));

endmodule

// File: rtl/tp_pat_gen.sv
module tp_pat_gen
  import tp_pkg::*;
#(
  parameter int MAX_W = 14,
  parameter int NB    = 8,
  localparam int UW   = 16,
  localparam int NW   = NB / 2,
  localparam int IW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [3:0]      mode_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [MAX_W-1:0] mask_i,
  input  logic [MAX_W-1:0] msb_i,
  input  logic [MAX_W-1:0] alt_i,
  input  logic [MAX_W-1:0] adc_i,
  input  logic [MAX_W-1:0] pnl_i,
  input  logic [MAX_W-1:0] pns_i,
  input  logic [8*NB-1:0]  bytes_i,
  output logic [MAX_W-1:0] raw_o,
  output logic             fmt_en_o
);

  logic [UW-1:0]    uw [NW];
  logic [UW-1:0]    usel;
  logic [MAX_W-1:0] uword;
  logic             second;

  for (genvar k = 0; k < NW; k++) begin : g_uw
    assign uw[k] = {bytes_i[8*(2*k+1) +: 8], bytes_i[8*(2*k) +: 8]};
  end

  assign usel = uw[idx_i];

  if (MAX_W < UW) begin : g_trunc
    logic unused_hi;
    assign uword     = usel[MAX_W-1:0];
    assign unused_hi = ^usel[UW-1:MAX_W];
  end else begin : g_full
    assign uword = MAX_W'(usel);
  end

  assign second = idx_i[0];

  always_comb begin
    case (mode_i)
      MODE_MID: raw_o = msb_i;
      MODE_POS: raw_o = mask_i;
      MODE_NEG: raw_o = '0;
      MODE_CHK: raw_o = second ? (~alt_i & mask_i) : alt_i;
      MODE_PNL: raw_o = pnl_i;
      MODE_PNS: raw_o = pns_i;
      MODE_TGL: raw_o = second ? '0 : mask_i;
      MODE_USR: raw_o = uword;
      default:  raw_o = adc_i;
    endcase
    fmt_en_o = fmt_applies(mode_i);
  end

endmodule

// File: rtl/test_pattern_sel.sv
module test_pattern_sel
  import tp_pkg::*;
#(
  parameter int MIN_W = 8,
  parameter int MAX_W = 14,
  parameter int NB    = 8,
  localparam int LW   = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en_i,
  input  logic [3:0]       mode_i,
  input  logic             fmt_twos_i,
  input  logic [LW-1:0]    wlen_i,
  input  logic [MAX_W-1:0] adc_data_i,
  input  logic [MAX_W-1:0] pn_long_i,
  input  logic [MAX_W-1:0] pn_short_i,
  input  logic [8*NB-1:0]  user_bytes_i,
  output logic [MAX_W-1:0] word_o,
  output logic             valid_o
);

  localparam int NW = NB / 2;
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;

  logic [MAX_W-1:0] mask, msb, alt, raw, word_d, word_q, mask_q;
  logic [IW-1:0]    idx;
  logic             fmt_en, valid_q;

  tp_len_dec #(.MIN_W(MIN_W), .MAX_W(MAX_W)) i_len (
    .wlen_i (wlen_i),
    .mask_o (mask),
    .msb_o  (msb),
    .alt_o  (alt)
  );

  tp_phase #(.NW(NW)) i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en_i (smp_en_i),
    .mode_i   (mode_i),
    .idx_o    (idx)
  );

  tp_pat_gen #(.MAX_W(MAX_W), .NB(NB)) i_gen (
    .mode_i   (mode_i),
    .idx_i    (idx),
    .mask_i   (mask),
    .msb_i    (msb),
    .alt_i    (alt),
    .adc_i    (adc_data_i),
    .pnl_i    (pn_long_i),
    .pns_i    (pn_short_i),
    .bytes_i  (user_bytes_i),
    .raw_o    (raw),
    .fmt_en_o (fmt_en)
  );

  always_comb begin
    word_d = raw;
    if (fmt_twos_i && fmt_en) word_d = word_d ^ msb;
    word_d = word_d & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mask_q <= '0;
    end else if (smp_en_i) begin
      word_q <= word_d;
      mask_q <= mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= smp_en_i;
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R10
  zero_above_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_o & ~mask_q) == '0);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en_i |=> valid_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en_i |=> (!valid_o && $stable(word_o)));

  // R4
  fixed_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && mode_i == MODE_POS && !fmt_twos_i) |=> (word_o == mask_q));

endmodule

// File: tb/test_test_pattern_sel.sv
module test_test_pattern_sel;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_W = 14;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_en_i;
  logic [3:0]        mode_i;
  logic              fmt_twos_i;
  logic [3:0]        wlen_i;
  logic [MAX_W-1:0]  adc_data_i, pn_long_i, pn_short_i;
  logic [63:0]       user_bytes_i;
  logic [MAX_W-1:0]  word_o;
  logic              valid_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int b_last = 0;
  int b_ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  test_pattern_sel i_test_pattern_sel (
    .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en_i), .mode_i(mode_i),
    .fmt_twos_i(fmt_twos_i), .wlen_i(wlen_i), .adc_data_i(adc_data_i),
    .pn_long_i(pn_long_i), .pn_short_i(pn_short_i),
    .user_bytes_i(user_bytes_i), .word_o(word_o), .valid_o(valid_o)
  );

  function automatic int act_len(input int wl);
    if (wl < 8) return 8;
    if (wl > 14) return 14;
    return wl;
  endfunction

  function automatic logic [MAX_W-1:0] model(input int m, input bit f, input int wl,
      input logic [MAX_W-1:0] d, input logic [MAX_W-1:0] pl, input logic [MAX_W-1:0] ps,
      input logic [63:0] by, input int idx);
    int L;
    logic [MAX_W-1:0] mask, ck, w;
    logic [15:0] u;
    L = act_len(wl);
    mask = '0;
    ck = '0;
    for (int i = 0; i < L; i++) begin
      mask[i] = 1'b1;
      if (((L - 1 - i) % 2) == 0) ck[i] = 1'b1;
    end
    case (m)
      1: w = MAX_W'(1) << (L - 1);
      2: w = mask;
      3: w = '0;
      4: w = (idx % 2 == 0) ? ck : (~ck & mask);
      5: w = pl;
      6: w = ps;
      7: w = (idx % 2 == 0) ? mask : '0;
      8: begin
        u = {by[8*(2*idx+1) +: 8], by[8*(2*idx) +: 8]};
        w = u[MAX_W-1:0];
      end
      default: w = d;
    endcase
    if (f && !(m == 4 || m == 7 || m == 8)) w[L-1] = ~w[L-1];
    return w & mask;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R3";
      1, 2, 3: return "R4";
      4, 7: return "R5";
      5, 6: return "R7";
      8: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [MAX_W-1:0] act, input logic [MAX_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One sample: drive at falling edge, registered at the rising edge, checked one falling edge later.
  task automatic run(input string tag, input int m, input bit f, input int wl,
      input logic [MAX_W-1:0] d, input bit use_x, input logic [MAX_W-1:0] xexp);
    int idx;
    logic [MAX_W-1:0] e;
    pn_long_i  = MAX_W'($urandom);
    pn_short_i = MAX_W'($urandom);
    idx = (m != b_last) ? 0 : b_ph;
    e = model(m, f, wl, d, pn_long_i, pn_short_i, user_bytes_i, idx);
    b_ph = (idx + 1) % 4;
    b_last = m;
    mode_i = 4'(m);
    fmt_twos_i = f;
    wlen_i = 4'(wl);
    adc_data_i = d;
    smp_en_i = 1'b1;
    @(negedge clk);
    chk(tag, word_o, use_x ? xexp : e);
    chk("R2", {13'd0, valid_o}, 14'd1);
  endtask

  task automatic idle(input int n);
    logic [MAX_W-1:0] held;
    held = word_o;
    smp_en_i = 1'b0;
    mode_i = 4'($urandom);
    adc_data_i = MAX_W'($urandom);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2", word_o, held);
      chk("R2", {13'd0, valid_o}, 14'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    smp_en_i = 1'b0;
    mode_i = 4'd0;
    fmt_twos_i = 1'b0;
    wlen_i = 4'd12;
    adc_data_i = '0;
    pn_long_i = '0;
    pn_short_i = '0;
    user_bytes_i = 64'h8877_6655_4433_2211;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", word_o, '0);
    chk("R1", {13'd0, valid_o}, 14'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", word_o, '0);

    // Directed corner cases
    run("R3", 0, 1, 12, 14'h0123, 1, 14'h0923);
    run("R10", 0, 0, 8, 14'h3FFF, 1, 14'h00FF);
    run("R4", 1, 0, 12, 0, 1, 14'h0800);
    run("R6", 1, 1, 12, 0, 1, 14'h0000);
    run("R4", 3, 0, 14, 0, 1, 14'h0000);
    run("R10", 2, 0, 3, 0, 1, 14'h00FF);
    run("R10", 2, 0, 15, 0, 1, 14'h3FFF);
    run("R5", 4, 1, 12, 0, 1, 14'h0AAA);
    run("R6", 4, 1, 12, 0, 1, 14'h0555);
    run("R9", 4, 1, 12, 0, 1, 14'h0AAA);
    run("R9", 7, 0, 8, 0, 1, 14'h00FF);
    run("R5", 7, 1, 8, 0, 1, 14'h0000);
    run("R9", 4, 0, 9, 0, 1, 14'h0155);
    run("R10", 4, 0, 9, 0, 1, 14'h00AA);
    idle(3);
    run("R8", 8, 1, 14, 0, 1, 14'h2211);
    run("R8", 8, 1, 14, 0, 1, 14'h0433);
    run("R8", 8, 0, 14, 0, 1, 14'h2655);
    run("R8", 8, 0, 14, 0, 1, 14'h0877);
    run("R8", 8, 0, 8, 0, 1, 14'h0011);
    run("R7", 5, 0, 14, 0, 0, 0);
    run("R7", 6, 1, 10, 0, 0, 0);
    run("R3", 11, 1, 13, 14'h1555, 1, 14'h0555);

    // Constrained random traffic
    for (int n = 0; n < 400; n++) begin
      int m;
      m = ($urandom % 4 == 0) ? int'($urandom % 16) : b_last;
      if ($urandom % 3 == 0) m = 4 + 4 * int'($urandom % 2);
      if ($urandom % 16 == 0) user_bytes_i = {$urandom, $urandom};
      run(tag_of(m), m, bit'($urandom % 2), int'($urandom % 16), MAX_W'($urandom), 0, 0);
      if ($urandom % 10 == 0) idle(1 + int'($urandom % 2));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule